// File: doc/BRIEF.md
# Serial Instruction-Cache Load Command Decoder

This block sits behind a 33-bit JTAG data register, clocked by the test clock. It turns a stream of serial packets into cache-maintenance requests for an instruction cache that has a main array and a mini array. Each packet is shifted in on TDI while the shift enable is high, least significant bit first. The packet is taken when the update strobe pulses.

The first packet of every command is a header. It carries a 3-bit operation code and a 27-bit line address, which is a 32-byte aligned address. The two invalidate operations need only the header and issue their request straight away. The two load operations need eight more packets, one instruction word each. Each of these words carries an even-parity bit. The block gathers the eight words into a line buffer and issues one write request for the whole line. It does so only if all eight words passed the parity check.

The bench and the cache see a single-cycle request pulse. The pulse carries the operation code, the line address and the eight-word line. Two sticky flags report bad command codes and parity failures. A test-logic reset returns the block to waiting for a header.

Top module: `icl_loader`

## Requirements
- R1: While shiftEn is high, one TDI bit per clock enters the 33-bit packet register. After 33 shifts, the first bit shifted sits in packet bit 0 and the last bit shifted sits in packet bit 32.
- R2: A packet is taken in the clock cycle where updateEn is high. In a header, bits [2:0] are the operation code and bits [32:6] are the line address. reqAddr changes only when a header is taken.
- R3: Header code 0 invalidates one line. reqValid is high for exactly the one cycle after the update, with reqOp = 0 and reqAddr equal to header bits [32:6].
- R4: Header code 1 invalidates the whole mini cache. reqValid pulses for one cycle after the update, with reqOp = 1.
- R5: Header code 2 (load main) and header code 3 (load mini) are each followed by exactly eight data packets. No request is made after the header or after data packets 0 to 6. After data packet 7, reqValid pulses for one cycle with reqOp equal to the header code and reqAddr equal to the header address.
- R6: During a load request, lineData bits [32*i+31:32*i] hold bits [31:0] of data packet i, for i = 0 to 7.
- R7: Bit 32 of a data packet makes the 33-bit packet have even parity. A data packet that breaks this sets parityErr, which stays set until reset. The request for that line is suppressed, but the block still takes all eight data packets.
- R8: Header codes 4 to 7 are ignored. No request is made, cmdErr is set and stays set until reset, and the next packet is treated as a header.
- R9: While testReset is high, the block clears reqValid, cmdErr, parityErr, the packet count, the address and the line buffer. The first packet after reset is treated as a header.
- R10: reqValid is high only in the cycle right after a cycle in which updateEn was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| testReset | input | 1 | Synchronous test-logic reset, active high |
| shiftEn | input | 1 | Shift one TDI bit into the packet register |
| updateEn | input | 1 | Take the current packet |
| tdi | input | 1 | Serial data in |
| reqValid | output | 1 | One-cycle cache request pulse |
| reqOp | output | 2 | Operation: 0 invalidate line, 1 invalidate mini, 2 load main, 3 load mini |
| reqAddr | output | 27 | Line address (byte address bits [31:5]) |
| lineData | output | 256 | Eight-word line buffer, word i at bits [32*i+31:32*i] |
| cmdErr | output | 1 | Sticky bad-command flag |
| parityErr | output | 1 | Sticky data-parity flag |

## Verification
The assertions check four things on every cycle. Each request follows an update. Both error flags stay set once raised. Reset clears the outputs. The line address holds steady between updates. Only the bench's packet sequences can show the rest. These are the bit order, decoding of each operation code, word placement in the line, suppression of a request for a line with a parity failure, and resynchronisation to a header after a bad code or a mid-load reset. The bench checks each of these against a model it computes from the packets it sends.

// File: rtl/icl_pkg.sv
package icl_pkg;
  localparam int PKT_W   = 33;
  localparam int WORD_W  = 32;
  localparam int WORDS   = 8;
  localparam int CMD_W   = 3;
  localparam int ADDR_W  = 27;
  localparam int IDX_W   = $clog2(WORDS);
  localparam int LINE_W  = WORDS * WORD_W;

  typedef enum logic [1:0] {
    OP_INV_LINE  = 2'd0,
    OP_INV_MINI  = 2'd1,
    OP_LOAD_MAIN = 2'd2,
    OP_LOAD_MINI = 2'd3
  } op_e;

  typedef struct packed {
    logic             takeHdr;
    logic             takeWord;
    logic [IDX_W-1:0] wordSel;
  } strobes_t;
endpackage

// File: rtl/icl_datapath.sv
module icl_datapath
  import icl_pkg::*;
(
  input  logic              clk,
  input  logic              testReset,
  input  logic              shiftEn,
  input  logic              tdi,
  input  strobes_t          strb,
  output logic [CMD_W-1:0]  hdrCmd,
  output logic              parityOk,
  output logic [ADDR_W-1:0] lineAddr,
  output logic [LINE_W-1:0] lineData
);
  logic [PKT_W-1:0] shiftReg;
  logic             unusedRsvd;

  always_ff @(posedge clk) begin
    if (testReset)    shiftReg <= '0;
    else if (shiftEn) shiftReg <= {tdi, shiftReg[PKT_W-1:1]};
  end

  assign hdrCmd     = shiftReg[CMD_W-1:0];
  assign parityOk   = ~(^shiftReg);
  assign unusedRsvd = ^shiftReg[PKT_W-ADDR_W-1:CMD_W];

  always_ff @(posedge clk) begin
    if (testReset)         lineAddr <= '0;
    else if (strb.takeHdr) lineAddr <= shiftReg[PKT_W-1:PKT_W-ADDR_W];
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (testReset)
        lineData[g*WORD_W +: WORD_W] <= '0;
      else if (strb.takeWord && strb.wordSel == IDX_W'(g))
        lineData[g*WORD_W +: WORD_W] <= shiftReg[WORD_W-1:0];
    end
  end
endmodule

// File: rtl/icl_ctrl.sv
module icl_ctrl
  import icl_pkg::*;
(
  input  logic             clk,
  input  logic             testReset,
  input  logic             updateEn,
  input  logic [CMD_W-1:0] hdrCmd,
  input  logic             parityOk,
  output strobes_t         strb,
  output logic             reqValid,
  output op_e              reqOp,
  output logic             cmdErr,
  output logic             parityErr
);
  logic             inData;
  logic [IDX_W-1:0] wordCnt;
  logic             loadMini;
  logic             lineBad;

  always_comb begin
    strb.takeHdr  = updateEn && !inData;
    strb.takeWord = updateEn && inData;
    strb.wordSel  = wordCnt;
  end

  always_ff @(posedge clk) begin
    if (testReset) begin
      inData    <= 1'b0;
      wordCnt   <= '0;
      loadMini  <= 1'b0;
      lineBad   <= 1'b0;
      reqValid  <= 1'b0;
      reqOp     <= OP_INV_LINE;
      cmdErr    <= 1'b0;
      parityErr <= 1'b0;
    end else begin
      reqValid <= 1'b0;
      if (strb.takeHdr) begin
        case (hdrCmd)
          3'd0: begin reqValid <= 1'b1; reqOp <= OP_INV_LINE; end
          3'd1: begin reqValid <= 1'b1; reqOp <= OP_INV_MINI; end
          3'd2, 3'd3: begin
            inData   <= 1'b1;
            wordCnt  <= '0;
            loadMini <= hdrCmd[0];
            lineBad  <= 1'b0;
          end
          default: cmdErr <= 1'b1;
        endcase
      end
      if (strb.takeWord) begin
        if (!parityOk) parityErr <= 1'b1;
        if (wordCnt == IDX_W'(WORDS-1)) begin
          inData  <= 1'b0;
          wordCnt <= '0;
          if (!lineBad && parityOk) begin
            reqValid <= 1'b1;
            reqOp    <= loadMini ? OP_LOAD_MINI : OP_LOAD_MAIN;
          end
        end else begin
          wordCnt <= wordCnt + 1'b1;
          lineBad <= lineBad | ~parityOk;
        end
      end
    end
  end
endmodule

// File: rtl/icl_loader.sv
module icl_loader
  import icl_pkg::*;
(
  input  logic              clk,
  input  logic              testReset,
  input  logic              shiftEn,
  input  logic              updateEn,
  input  logic              tdi,
  output logic              reqValid,
  output logic [1:0]        reqOp,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [LINE_W-1:0] lineData,
  output logic              cmdErr,
  output logic              parityErr
);
  strobes_t         strb;
  logic [CMD_W-1:0] hdrCmd;
  logic             parityOk;
  op_e              opSel;

  icl_datapath dp_i (
    .clk(clk), .testReset(testReset), .shiftEn(shiftEn), .tdi(tdi),
    .strb(strb), .hdrCmd(hdrCmd), .parityOk(parityOk),
    .lineAddr(reqAddr), .lineData(lineData)
  );

  icl_ctrl ctrl_i (
    .clk(clk), .testReset(testReset), .updateEn(updateEn),
    .hdrCmd(hdrCmd), .parityOk(parityOk), .strb(strb),
    .reqValid(reqValid), .reqOp(opSel), .cmdErr(cmdErr), .parityErr(parityErr)
  );

  assign reqOp = opSel;
endmodule

// File: rtl/icl_checks.sv
module icl_checks #(parameter int AW = 27) (
  input logic          clk,
  input logic          testReset,
  input logic          updateEn,
  input logic          reqValid,
  input logic [AW-1:0] reqAddr,
  input logic          cmdErr,
  input logic          parityErr
);
  a_r10_req_after_update: assert property (@(posedge clk) disable iff (testReset)
    reqValid |-> $past(updateEn));

  a_r7_parity_sticky: assert property (@(posedge clk) disable iff (testReset)
    parityErr |=> parityErr);

  a_r8_cmderr_sticky: assert property (@(posedge clk) disable iff (testReset)
    cmdErr |=> cmdErr);

  a_r2_addr_holds: assert property (@(posedge clk) disable iff (testReset)
    !updateEn |=> $stable(reqAddr));

  a_r9_reset_clears: assert property (@(posedge clk)
    testReset |=> (!reqValid && !cmdErr && !parityErr && reqAddr == '0));
endmodule

bind icl_loader icl_checks #(.AW(icl_pkg::ADDR_W)) chk_i (
  .clk(clk), .testReset(testReset), .updateEn(updateEn), .reqValid(reqValid),
  .reqAddr(reqAddr), .cmdErr(cmdErr), .parityErr(parityErr)
);

// File: tb/icl_loader_tb_top.sv
module icl_loader_tb_top;
  logic         clk = 1'b0;
  logic         testReset = 1'b1;
  logic         shiftEn = 1'b0;
  logic         updateEn = 1'b0;
  logic         tdi = 1'b0;
  logic         reqValid;
  logic [1:0]   reqOp;
  logic [26:0]  reqAddr;
  logic [255:0] lineData;
  logic         cmdErr;
  logic         parityErr;

  int checks = 0;
  int errors = 0;
  logic expCmdErr = 1'b0;
  logic expParErr = 1'b0;

  always #4 clk = ~clk;

  icl_loader dut_i (
    .clk(clk), .testReset(testReset), .shiftEn(shiftEn), .updateEn(updateEn),
    .tdi(tdi), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .lineData(lineData), .cmdErr(cmdErr), .parityErr(parityErr)
  );

  function automatic logic [32:0] hdrPkt(input logic [2:0] cmd, input logic [26:0] addr);
    return {addr, 3'b000, cmd};
  endfunction

  function automatic logic [32:0] dataPkt(input logic [31:0] w, input logic flip);
    return {(^w) ^ flip, w};
  endfunction

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sendPkt(input logic [32:0] p);
    for (int i = 0; i < 33; i++) begin
      @(negedge clk); shiftEn = 1'b1; tdi = p[i];
    end
    @(negedge clk); shiftEn = 1'b0; updateEn = 1'b1;
    @(negedge clk); updateEn = 1'b0;
  endtask

  task automatic checkFlags(input string req);
    check({req, " cmdErr"}, 256'(cmdErr), 256'(expCmdErr));
    check({req, " parityErr"}, 256'(parityErr), 256'(expParErr));
  endtask

  task automatic doInv(input logic mini, input logic [26:0] addr);
    sendPkt(hdrPkt({2'b00, mini}, addr));
    check(mini ? "R4 req" : "R3 req", 256'(reqValid), 256'(1));
    check(mini ? "R4 op" : "R3 op", 256'(reqOp), 256'(mini));
    if (!mini) check("R3 addr", 256'(reqAddr), 256'(addr));
    @(negedge clk);
    check("R3 one-cycle pulse", 256'(reqValid), 256'(0));
  endtask

  task automatic doLoad(input logic mini, input logic [26:0] addr, input int badIdx);
    logic [255:0] line;
    sendPkt(hdrPkt({2'b01, mini}, addr));
    check("R5 no req on header", 256'(reqValid), 256'(0));
    for (int i = 0; i < 8; i++) begin
      logic [31:0] w;
      w = $urandom;
      line[i*32 +: 32] = w;
      sendPkt(dataPkt(w, i == badIdx));
      if (i < 7) check("R5 no req mid-line", 256'(reqValid), 256'(0));
    end
    if (badIdx >= 0) begin
      expParErr = 1'b1;
      check("R7 suppressed", 256'(reqValid), 256'(0));
    end else begin
      check("R5 req", 256'(reqValid), 256'(1));
      check("R5 op", 256'(reqOp), 256'({1'b1, mini}));
      check("R5 addr", 256'(reqAddr), 256'(addr));
      check("R6 line", lineData, line);
    end
    checkFlags("R7/R8");
  endtask

  task automatic doReset();
    @(negedge clk); testReset = 1'b1;
    @(negedge clk); @(negedge clk); testReset = 1'b0;
    expCmdErr = 1'b0; expParErr = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1c01));
    repeat (3) @(negedge clk);
    testReset = 1'b0;
    // R9 reset state
    check("R9 reqValid", 256'(reqValid), 256'(0));
    check("R9 addr", 256'(reqAddr), 256'(0));
    check("R9 line", lineData, 256'(0));
    checkFlags("R9");
    // R1/R2 bit order: distinct end bits of the address
    doInv(1'b0, 27'h4000001);
    doInv(1'b1, 27'h0);
    doLoad(1'b0, 27'h1234567, -1);
    doLoad(1'b1, 27'h7ffffff, -1);
    // R7 bad parity on first and last word
    doLoad(1'b0, 27'h0000abc, 0);
    doLoad(1'b1, 27'h0000def, 7);
    // R8 bad code then header resync
    sendPkt(hdrPkt(3'd5, 27'h55));
    expCmdErr = 1'b1;
    check("R8 no req", 256'(reqValid), 256'(0));
    checkFlags("R8");
    doInv(1'b0, 27'h123);
    // R9 reset mid-load, next packet is header
    doReset();
    checkFlags("R9 cleared");
    sendPkt(hdrPkt(3'd2, 27'h77));
    sendPkt(dataPkt(32'h0, 1'b0));
    sendPkt(dataPkt(32'h3, 1'b0));
    doReset();
    check("R9 line cleared", lineData, 256'(0));
    doInv(1'b0, 27'h2468);
    // random mix
    for (int t = 0; t < 40; t++) begin
      int kind;
      logic [26:0] a;
      kind = int'($urandom % 6);
      a = 27'($urandom);
      case (kind)
        0: doInv(1'b0, a);
        1: doInv(1'b1, a);
        2: doLoad(1'b0, a, -1);
        3: doLoad(1'b1, a, -1);
        4: begin
          sendPkt(hdrPkt(3'd4 + 3'($urandom % 4), a));
          expCmdErr = 1'b1;
          check("R8 no req", 256'(reqValid), 256'(0));
          checkFlags("R8");
        end
        default: doLoad(1'($urandom), a, int'($urandom % 8));
      endcase
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule